// File: doc/BRIEF.md
# Three-Beat Packet Validator

This block sits on a 32-bit stream that carries 96-bit packets as three consecutive beats, each qualified by an input valid strobe. It holds the first two beats of a packet. When the final beat arrives it checks three fixed fields: the header code in the low bits of the leading beat, the tail code in the top bits of the final beat, and the 6-bit hop count in the final beat against a parameter limit. Only a packet that passes all three checks is replayed on the output, beat by beat, with an output valid strobe. A failing packet is discarded, and no indication of the drop is given.

The middle beat is never inspected. Input valid may drop between beats or between packets, and those idle cycles have no effect. The output stage can drain one accepted packet while the next one is being captured, so packets may arrive back to back with no idle cycle between them.

Top module: `pkt_validator`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, valid_o is 0 and data_o is all zero.
- R2: A packet whose leading-beat bits [2:0] equal 3'b101, whose final-beat bits [31:29] equal 3'b010 and whose final-beat hop field [8:3] is at most HOP_LIMIT (default 15) is forwarded. Its leading, middle and final beats appear on data_o, with valid_o high, on the first, second and third cycles after the clock edge that samples the final beat.
- R3: A packet whose leading-beat bits [2:0] differ from 3'b101 (for example 3'b111) is dropped, and it causes no valid_o pulse.
- R4: A packet whose final-beat bits [31:29] differ from 3'b010 (for example 3'b000) is dropped.
- R5: A packet whose unsigned hop field [8:3] exceeds HOP_LIMIT is dropped. With the default limit, counts of 5, 8, 9 and 15 pass, while 16 and 21 are dropped.
- R6: Cycles with valid_i low do not advance the beat position, either inside a packet or between packets. A packet whose beats are separated by idle cycles is assembled exactly as if its beats were contiguous.
- R7: A new packet may start on the cycle right after a final beat. Consecutive accepted packets come out as one unbroken run of valid_o.
- R8: Whenever valid_o is low, data_o is all zero.
- R9: The content of the middle beat does not affect acceptance, and the middle beat is forwarded unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 32 | Input beat |
| valid_i | input | 1 | Qualifies data_i |
| data_o | output | 32 | Forwarded beat, zero when idle |
| valid_o | output | 1 | Qualifies data_o |

## Verification
A passing packet's three beats are due on the first, second and third cycles after the edge that samples its final beat. The driver records that edge's cycle number and queues each expected beat together with the cycle it is due in. The monitor samples the outputs on the falling edge. It pops an entry whenever valid_o is high and requires both the data and the cycle number to match. If an entry falls due and no valid_o appears, or valid_o appears with the queue empty, it reports a failure against the requirement of the packet just driven. In that way dropped packets, gapped beats and back-to-back packets are all judged on the same cycle-exact terms.

// File: rtl/pkt_validator_pkg.sv
package pkt_validator_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_BEATS = 3;
  localparam int CNT_W     = $clog2(NUM_BEATS);
  localparam int REM_W     = $clog2(NUM_BEATS + 1);

  // leading beat
  localparam int HDR_LSB = 0;
  localparam int HDR_W   = 3;
  localparam logic [HDR_W-1:0] HDR_CODE = 3'b101;

  // final beat
  localparam int TAIL_LSB = 29;
  localparam int TAIL_W   = 3;
  localparam logic [TAIL_W-1:0] TAIL_CODE = 3'b010;
  localparam int HOP_LSB  = 3;
  localparam int HOP_W    = 6;

  typedef logic [DATA_W-1:0] beat_t;
endpackage

// File: rtl/pkt_beat_capture.sv
module pkt_beat_capture
  import pkt_validator_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  beat_t                          data_i,
  input  logic                           valid_i,
  output logic [NUM_BEATS-2:0][DATA_W-1:0] held_o,
  output logic                           last_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_BEATS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (valid_i) cnt_q <= (cnt_q == LAST_IDX) ? '0 : cnt_q + 1'b1;
  end

  for (genvar i = 0; i < NUM_BEATS - 1; i++) begin : g_hold
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) held_o[i] <= '0;
      else if (valid_i && cnt_q == CNT_W'(i)) held_o[i] <= data_i;
    end
  end

  assign last_o = valid_i && (cnt_q == LAST_IDX);
endmodule

// File: rtl/pkt_field_check.sv
module pkt_field_check
  import pkt_validator_pkg::*;
#(
  parameter int HOP_LIMIT = 15
) (
  input  beat_t lead_i,
  input  beat_t final_i,
  output logic  pass_o
);
  logic [HDR_W-1:0]  hdr;
  logic [TAIL_W-1:0] tail;
  logic [HOP_W-1:0]  hop;
  logic hdr_ok, tail_ok, hop_ok;

  always_comb begin
    hdr     = lead_i[HDR_LSB +: HDR_W];
    tail    = final_i[TAIL_LSB +: TAIL_W];
    hop     = final_i[HOP_LSB +: HOP_W];
    hdr_ok  = (hdr == HDR_CODE);
    tail_ok = (tail == TAIL_CODE);
    hop_ok  = (int'(hop) <= HOP_LIMIT);
    pass_o  = hdr_ok && tail_ok && hop_ok;
  end
endmodule

// File: rtl/pkt_out_drain.sv
module pkt_out_drain
  import pkt_validator_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           load_i,
  input  logic [NUM_BEATS-1:0][DATA_W-1:0] beats_i,
  output beat_t                          data_o,
  output logic                           valid_o
);
  localparam int PEND = NUM_BEATS - 1;

  logic [PEND-1:0][DATA_W-1:0] pend_q;
  logic [CNT_W-1:0]            rem_q;

  // a load always wins: the previous packet's last beat is already on data_o
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      rem_q   <= '0;
    end else if (load_i) begin
      data_o  <= beats_i[0];
      valid_o <= 1'b1;
      rem_q   <= CNT_W'(PEND);
    end else if (rem_q != '0) begin
      data_o  <= pend_q[0];
      valid_o <= 1'b1;
      rem_q   <= rem_q - 1'b1;
    end else begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end
  end

  for (genvar i = 0; i < PEND; i++) begin : g_pend
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[i] <= '0;
      else if (load_i) pend_q[i] <= beats_i[i+1];
      else if (rem_q != '0) begin
        if (i == PEND - 1) pend_q[i] <= '0;
        else               pend_q[i] <= pend_q[(i+1) % PEND];
      end
    end
  end
endmodule

// File: rtl/pkt_validator.sv
module pkt_validator
  import pkt_validator_pkg::*;
#(
  parameter int HOP_LIMIT = 15
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] data_i,
  input  logic        valid_i,
  output logic [31:0] data_o,
  output logic        valid_o
);
  logic [NUM_BEATS-2:0][DATA_W-1:0] held;
  logic [NUM_BEATS-1:0][DATA_W-1:0] beats;
  logic last, pass;

  pkt_beat_capture u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .data_i  (data_i),
    .valid_i (valid_i),
    .held_o  (held),
    .last_o  (last)
  );

  assign beats = {data_i, held};

  pkt_field_check #(.HOP_LIMIT(HOP_LIMIT)) u_check (
    .lead_i  (held[0]),
    .final_i (data_i),
    .pass_o  (pass)
  );

  pkt_out_drain u_drain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (last && pass),
    .beats_i (beats),
    .data_o  (data_o),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/pkt_validator_chk.sv
module pkt_validator_chk
  import pkt_validator_pkg::*;
#(
  parameter int HOP_LIMIT = 15
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] data_i,
  input logic        valid_i,
  input logic [31:0] data_o,
  input logic        valid_o
);
  logic [CNT_W-1:0] pos_q;
  beat_t            b0_q, b1_q;
  logic [REM_W-1:0] rem_q;
  logic             last, hdr_bad, tail_bad, hop_bad, ok;

  assign last     = valid_i && (pos_q == CNT_W'(NUM_BEATS - 1));
  assign hdr_bad  = b0_q[HDR_LSB +: HDR_W] != HDR_CODE;
  assign tail_bad = data_i[TAIL_LSB +: TAIL_W] != TAIL_CODE;
  assign hop_bad  = int'(data_i[HOP_LSB +: HOP_W]) > HOP_LIMIT;
  assign ok       = !hdr_bad && !tail_bad && !hop_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      b0_q  <= '0;
      b1_q  <= '0;
      rem_q <= '0;
    end else begin
      if (valid_i) begin
        if (pos_q == CNT_W'(0)) b0_q <= data_i;
        if (pos_q == CNT_W'(1)) b1_q <= data_i;
        pos_q <= last ? '0 : pos_q + 1'b1;
      end
      if (last && ok)          rem_q <= REM_W'(NUM_BEATS);
      else if (rem_q != '0)    rem_q <= rem_q - 1'b1;
    end
  end

  a_r2_valid_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == (rem_q != '0));
  a_r2_first_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && ok) |=> (valid_o && data_o == $past(b0_q)));
  a_r9_mid_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && ok) |=> ##1 (data_o == $past(b1_q, 2)));
  a_r2_final_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && ok) |=> ##2 (data_o == $past(data_i, 3)));
  a_r3_header_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && hdr_bad && rem_q <= REM_W'(1)) |=> !valid_o);
  a_r4_tail_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && tail_bad && rem_q <= REM_W'(1)) |=> !valid_o);
  a_r5_hop_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && hop_bad && rem_q <= REM_W'(1)) |=> !valid_o);
  a_r8_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (data_o == '0));
endmodule

bind pkt_validator pkt_validator_chk #(.HOP_LIMIT(15)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .data_i  (data_i),
  .valid_i (valid_i),
  .data_o  (data_o),
  .valid_o (valid_o)
);

// File: tb/pkt_validator_test.sv
module pkt_validator_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOP_LIMIT  = 15;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] data_i = '0;
  logic        valid_i = 1'b0;
  logic [31:0] data_o;
  logic        valid_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  bit mon_on = 1'b0;
  string cur_req = "R1";

  logic [31:0] exp_d[$];
  int          exp_t[$];
  string       exp_r[$];

  pkt_validator #(.HOP_LIMIT(HOP_LIMIT)) uut (
    .clk_i (clk_i), .rst_ni (rst_ni), .data_i (data_i),
    .valid_i (valid_i), .data_o (data_o), .valid_o (valid_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [31:0] lead_beat(logic [28:0] pay, logic [2:0] hdr);
    return {pay, hdr};
  endfunction

  function automatic logic [31:0] final_beat(logic [2:0] tail, logic [9:0] src,
                                             logic [9:0] dst, logic [5:0] hop);
    return {tail, src, dst, hop, 3'b011};
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      data_i  = '0;
      valid_i = 1'b0;
    end
  endtask

  // gap: idle cycles inserted before each of the later beats
  task automatic send(logic [31:0] b0, logic [31:0] b1, logic [31:0] b2,
                      bit pass, string req, int gap);
    logic [31:0] bs [3];
    bs[0] = b0; bs[1] = b1; bs[2] = b2;
    cur_req = req;
    for (int i = 0; i < 3; i++) begin
      if (i > 0 && gap > 0) idle(gap);
      @(negedge clk_i);
      data_i  = bs[i];
      valid_i = 1'b1;
    end
    if (pass) begin
      for (int i = 0; i < 3; i++) begin
        exp_d.push_back(bs[i]);
        exp_t.push_back(cyc + 1 + i);
        exp_r.push_back(req);
      end
    end
  endtask

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (mon_on && !done) begin
      if (valid_o) begin
        if (exp_d.size() == 0) begin
          check(1'b0, cur_req, data_o, 32'h0, "unexpected output beat");
        end else begin
          logic [31:0] d;
          int t;
          string r;
          d = exp_d.pop_front();
          t = exp_t.pop_front();
          r = exp_r.pop_front();
          check(data_o == d, r, data_o, d, "beat data");
          check(cyc == t, r, 32'(cyc), 32'(t), "beat cycle");
        end
      end else begin
        check(data_o == '0, "R8", data_o, 32'h0, "idle data");
        if (exp_t.size() != 0 && exp_t[0] <= cyc) begin
          check(1'b0, exp_r[0], 32'h0, exp_d[0], "missing beat");
          void'(exp_d.pop_front());
          void'(exp_t.pop_front());
          void'(exp_r.pop_front());
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk_i);
    check(valid_o == 1'b0, "R1", 32'(valid_o), 32'h0, "valid in reset");
    check(data_o == '0, "R1", data_o, 32'h0, "data in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(valid_o == 1'b0 && data_o == '0, "R1", data_o, 32'h0, "after release");
    mon_on = 1'b1;

    // R2: basic pass, hop 5
    send(lead_beat(29'd123, 3'b101), 32'd321, final_beat(3'b010, 10'd98, 10'd99, 6'd5), 1, "R2", 0);
    idle(6);
    // R5: hops 8 and 9 pass
    send(lead_beat(29'd7, 3'b101), 32'hA5A5_0001, final_beat(3'b010, 10'd980, 10'd990, 6'd8), 1, "R5", 0);
    idle(5);
    send(lead_beat(29'd8, 3'b101), 32'hA5A5_0002, final_beat(3'b010, 10'd1, 10'd2, 6'd9), 1, "R5", 0);
    idle(5);
    // R3: bad header
    send(lead_beat(29'd1234, 3'b111), 32'd3210, final_beat(3'b010, 10'd980, 10'd990, 6'd8), 0, "R3", 0);
    idle(6);
    // R4: bad tail
    send(lead_beat(29'd1234, 3'b101), 32'd3210, final_beat(3'b000, 10'd980, 10'd990, 6'd9), 0, "R4", 0);
    idle(6);
    // R5: hop 21 and 16 drop, 15 passes
    send(lead_beat(29'd1234, 3'b101), 32'd3210, final_beat(3'b010, 10'd980, 10'd990, 6'd21), 0, "R5", 0);
    idle(6);
    send(lead_beat(29'd11, 3'b101), 32'd0, final_beat(3'b010, 10'd3, 10'd4, 6'd16), 0, "R5", 0);
    idle(6);
    send(lead_beat(29'd12, 3'b101), 32'hFFFF_FFFF, final_beat(3'b010, 10'd5, 10'd6, 6'd15), 1, "R5", 0);
    idle(6);
    // R9: middle beat carrying code-like bits is ignored
    send(lead_beat(29'h1ABCDEF, 3'b101), 32'h4000_0007, final_beat(3'b010, 10'd1023, 10'd0, 6'd0), 1, "R9", 0);
    idle(6);
    // R6: gapped beats
    send(lead_beat(29'd55, 3'b101), 32'hDEAD_BEEF, final_beat(3'b010, 10'd9, 10'd10, 6'd3), 1, "R6", 2);
    idle(6);
    // R7: back-to-back, with a dropped packet in the middle of the run
    send(lead_beat(29'd101, 3'b101), 32'h0000_1111, final_beat(3'b010, 10'd11, 10'd12, 6'd1), 1, "R7", 0);
    send(lead_beat(29'd102, 3'b101), 32'h0000_2222, final_beat(3'b010, 10'd13, 10'd14, 6'd2), 1, "R7", 0);
    send(lead_beat(29'd103, 3'b110), 32'h0000_3333, final_beat(3'b010, 10'd15, 10'd16, 6'd3), 0, "R3", 0);
    send(lead_beat(29'd104, 3'b101), 32'h0000_4444, final_beat(3'b010, 10'd17, 10'd18, 6'd4), 1, "R7", 0);
    idle(8);
    check(exp_d.size() == 0, "R2", 32'(exp_d.size()), 32'h0, "queue drained");
    finish_run();
  end
endmodule